// File: doc/BRIEF.md
# Toggle-Signalled Sector Word Receiver

This block takes in one sector of 16-bit words from a producer that runs on its own clock. The producer does not drive a valid level. It drives the word and then flips a request line once, so that each change of level, in either direction, stands for one word. The receiver passes the request line through a synchronizer chain. An edge detector turns each change into a one-cycle strobe, and the receiver captures the data bus one cycle after that strobe. By then the bus has been stable for several receiver cycles.

A sector has a fixed field order: the main payload first, then an optional block of flag words, then an optional block of subcode words, and last two status words. The receiver counts words and keeps a pointer to the current field. It steps over any field whose enable input is clear. It emits every word with a two-bit field tag, and it pulses an end-of-sector strobe together with the last status word. It keeps both status words in registers until the next sector replaces them. The enable inputs are sampled once, when the first word of a sector is captured, so the layout of a sector cannot change while it is in flight.

Top module: `sector_rx`

## Requirements
- R1: While reset is high, and after it is released, `out_valid` and `sector_end` are 0 and `stat_lo` and `stat_hi` are 0.
- R2: The producer changes `word_in` only when it flips `req_tgl`, and then holds both for at least 4 receiver clock cycles. Under that condition each flip of `req_tgl`, rising or falling, gives exactly one cycle of `out_valid`, and `out_word` equals the `word_in` value that came with that flip. No word is lost and none is duplicated.
- R3: `out_valid` goes high after the fourth rising `clk` edge that follows a flip of `req_tgl` made synchronously to `clk`. It is still low after the third such edge.
- R4: `out_field` encodes the field of each word: 0 for main payload, 1 for flag words, 2 for subcode words and 3 for status words. The first `MAIN_WORDS` words of each sector carry tag 0.
- R5: When the flag field is enabled for a sector (`flag_en` = 1), exactly `FLAG_WORDS` words tagged 1 follow the main payload. When it is disabled, no word of that sector carries tag 1.
- R6: When the subcode field is enabled for a sector (`sub_en` = 1), exactly `SUB_WORDS` words tagged 2 follow the main payload and any flag words. When it is disabled, no word of that sector carries tag 2.
- R7: Every sector ends with exactly two words tagged 3. `sector_end` is high for one cycle, in the same cycle as `out_valid` for the second of those two words, and it is never high in any other cycle.
- R8: `stat_lo` takes the first status word and `stat_hi` takes the second, both in the cycle the word appears on `out_word`. Both hold those values through the following sector until its own status words arrive.
- R9: `flag_en` and `sub_en` are sampled when the first word of a sector is captured. Changing them later in the sector does not change that sector's field tags or length. The new values apply from the next sector on.
- R10: After the last status word, the next word is tagged 0 and begins a fresh main payload of `MAIN_WORDS` words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous active-high reset |
| req_tgl | input | 1 | Request line from the producer's clock domain; each change of level marks a word |
| word_in | input | DATA_W | Word from the producer, stable around each request change |
| flag_en | input | 1 | Enables the flag field; sampled at the first word of a sector |
| sub_en | input | 1 | Enables the subcode field; sampled at the first word of a sector |
| out_valid | output | 1 | One-cycle strobe for each received word |
| out_word | output | DATA_W | Received word |
| out_field | output | 2 | Field tag of `out_word` (0 main, 1 flag, 2 subcode, 3 status) |
| sector_end | output | 1 | Pulses with the second status word |
| stat_lo | output | DATA_W | First status word of the latest sector |
| stat_hi | output | DATA_W | Second status word of the latest sector |

## Verification
The bench builds the receiver with a 20-word main field, 6 flag words and 5 subcode words. It keeps the default 16-bit data and two-stage synchronizer. With these short fields a single run covers every field boundary many times: each of the four enable combinations, back-to-back sectors, and enable changes in the middle of a sector. The request gaps are random, and status-word retention is checked across the sector that follows. At the default lengths, one sector of a single combination would cost more run time than all of these cases together.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [1:0] {
    FLD_MAIN = 2'd0,
    FLD_FLAG = 2'd1,
    FLD_SUB  = 2'd2,
    FLD_STAT = 2'd3
  } fld_e;

  localparam int STAT_COUNT = 2;

endpackage

// File: rtl/sr_toggle_sync.sv
module sr_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_async,
  output logic strobe
);

  logic [STAGES-1:0] chain_q;
  logic              seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      seen_q  <= 1'b0;
      strobe  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], tgl_async};
      seen_q  <= chain_q[STAGES-1];
      strobe  <= chain_q[STAGES-1] ^ seen_q;
    end
  end

  // R2
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

endmodule

// File: rtl/sr_field_seq.sv
module sr_field_seq
  import sr_pkg::*;
#(
  parameter int MAIN_WORDS = 1176,
  parameter int FLAG_WORDS = 148,
  parameter int SUB_WORDS  = 57
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic cfg_flag,
  input  logic cfg_sub,
  output fld_e cur_fld,
  output logic stat_sel,
  output logic last_word
);

  localparam int MAX_A  = (MAIN_WORDS > FLAG_WORDS) ? MAIN_WORDS : FLAG_WORDS;
  localparam int MAX_B  = (SUB_WORDS > STAT_COUNT) ? SUB_WORDS : STAT_COUNT;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_start_q;
  logic             en_flag_q;
  logic             en_sub_q;
  logic             eff_flag;
  logic             eff_sub;
  logic [CNT_W-1:0] fld_last;
  logic             fld_done;
  fld_e             nxt_fld;

  function automatic logic [CNT_W-1:0] last_idx(input fld_e f);
    case (f)
      FLD_MAIN: last_idx = CNT_W'(MAIN_WORDS - 1);
      FLD_FLAG: last_idx = CNT_W'(FLAG_WORDS - 1);
      FLD_SUB:  last_idx = CNT_W'(SUB_WORDS - 1);
      default:  last_idx = CNT_W'(STAT_COUNT - 1);
    endcase
  endfunction

  always_comb begin
    eff_flag = at_start_q ? cfg_flag : en_flag_q;
    eff_sub  = at_start_q ? cfg_sub  : en_sub_q;
    fld_last = last_idx(cur_fld);
    fld_done = (cnt_q == fld_last);
    case (cur_fld)
      FLD_MAIN: nxt_fld = eff_flag ? FLD_FLAG : (eff_sub ? FLD_SUB : FLD_STAT);
      FLD_FLAG: nxt_fld = eff_sub ? FLD_SUB : FLD_STAT;
      FLD_SUB:  nxt_fld = FLD_STAT;
      default:  nxt_fld = FLD_MAIN;
    endcase
  end

  assign stat_sel  = cnt_q[0];
  assign last_word = (cur_fld == FLD_STAT) && fld_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      cur_fld    <= FLD_MAIN;
      at_start_q <= 1'b1;
      en_flag_q  <= 1'b0;
      en_sub_q   <= 1'b0;
    end else if (step) begin
      if (at_start_q) begin
        en_flag_q  <= cfg_flag;
        en_sub_q   <= cfg_sub;
        at_start_q <= 1'b0;
      end
      if (fld_done) begin
        cnt_q   <= '0;
        cur_fld <= nxt_fld;
        if (cur_fld == FLD_STAT) at_start_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_idx(cur_fld));

  // R5
  flag_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_fld == FLD_FLAG) |-> (en_flag_q && !at_start_q));

  // R6
  sub_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_fld == FLD_SUB) |-> (en_sub_q && !at_start_q));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!at_start_q && !$past(at_start_q)) |-> ($stable(en_flag_q) && $stable(en_sub_q)));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    at_start_q |-> (cur_fld == FLD_MAIN && cnt_q == '0));

endmodule

// File: rtl/sr_word_out.sv
module sr_word_out
  import sr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] word_in,
  input  fld_e              fld,
  input  logic              stat_sel,
  input  logic              last_word,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_word,
  output logic [1:0]        out_field,
  output logic              sector_end,
  output logic [DATA_W-1:0] stat_lo,
  output logic [DATA_W-1:0] stat_hi
);

  logic is_stat;
  assign is_stat = (fld == FLD_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_field  <= 2'd0;
      sector_end <= 1'b0;
      stat_lo    <= '0;
      stat_hi    <= '0;
    end else begin
      out_valid  <= capture;
      sector_end <= capture && last_word;
      if (capture) begin
        out_word  <= word_in;
        out_field <= fld;
        if (is_stat && !stat_sel) stat_lo <= word_in;
        if (is_stat &&  stat_sel) stat_hi <= word_in;
      end
    end
  end

  // R7
  end_align_chk: assert property (@(posedge clk) disable iff (rst)
    sector_end |-> (out_valid && out_field == 2'd3));

  // R8
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_field == 2'd3) |-> ($stable(stat_lo) && $stable(stat_hi)));

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

endmodule

// File: rtl/sector_rx.sv
module sector_rx
  import sr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MAIN_WORDS  = 1176,
  parameter int FLAG_WORDS  = 148,
  parameter int SUB_WORDS   = 57
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tgl,
  input  logic [DATA_W-1:0] word_in,
  input  logic              flag_en,
  input  logic              sub_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_word,
  output logic [1:0]        out_field,
  output logic              sector_end,
  output logic [DATA_W-1:0] stat_lo,
  output logic [DATA_W-1:0] stat_hi
);

  logic strobe;
  fld_e cur_fld;
  logic stat_sel;
  logic last_word;

  sr_toggle_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .tgl_async (req_tgl),
    .strobe    (strobe)
  );

  sr_field_seq #(
    .MAIN_WORDS(MAIN_WORDS),
    .FLAG_WORDS(FLAG_WORDS),
    .SUB_WORDS (SUB_WORDS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .step      (strobe),
    .cfg_flag  (flag_en),
    .cfg_sub   (sub_en),
    .cur_fld   (cur_fld),
    .stat_sel  (stat_sel),
    .last_word (last_word)
  );

  sr_word_out #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .capture    (strobe),
    .word_in    (word_in),
    .fld        (cur_fld),
    .stat_sel   (stat_sel),
    .last_word  (last_word),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .out_field  (out_field),
    .sector_end (sector_end),
    .stat_lo    (stat_lo),
    .stat_hi    (stat_hi)
  );

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !sector_end));

endmodule

// File: tb/sector_rx_bench.sv
module sector_rx_bench;

  localparam int DW = 16;
  localparam int NM = 20;
  localparam int NF = 6;
  localparam int NS = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_tgl = 1'b0;
  logic [DW-1:0] word_in = '0;
  logic          flag_en = 1'b0;
  logic          sub_en = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_word;
  logic [1:0]    out_field;
  logic          sector_end;
  logic [DW-1:0] stat_lo;
  logic [DW-1:0] stat_hi;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [DW-1:0] q_word[$];
  logic [1:0]    q_fld[$];
  bit            q_end[$];
  logic [DW-1:0] prev_lo = '0;
  logic [DW-1:0] prev_hi = '0;

  always #2.5 clk = ~clk;

  sector_rx #(
    .DATA_W(DW), .SYNC_STAGES(2),
    .MAIN_WORDS(NM), .FLAG_WORDS(NF), .SUB_WORDS(NS)
  ) u_sector_rx (
    .clk(clk), .rst(rst), .req_tgl(req_tgl), .word_in(word_in),
    .flag_en(flag_en), .sub_en(sub_en), .out_valid(out_valid),
    .out_word(out_word), .out_field(out_field), .sector_end(sector_end),
    .stat_lo(stat_lo), .stat_hi(stat_hi)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sector_len(input bit ef, input bit es);
    return NM + (ef ? NF : 0) + (es ? NS : 0) + 2;
  endfunction

  function automatic logic [1:0] tag_of(input int i, input bit ef, input bit es);
    int b = NM;
    if (i < b) return 2'd0;
    if (ef) begin
      if (i < b + NF) return 2'd1;
      b += NF;
    end
    if (es) begin
      if (i < b + NS) return 2'd2;
    end
    return 2'd3;
  endfunction

  // Output monitor: R2, R4, R5, R6, R7, R10
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (out_valid) begin
        if (q_word.size() == 0) begin
          check(0, "R2", "unexpected word", out_word, 0);
        end else begin
          logic [DW-1:0] ew;
          logic [1:0]    ef;
          bit            ee;
          ew = q_word.pop_front();
          ef = q_fld.pop_front();
          ee = q_end.pop_front();
          check(out_word == ew, "R2", "word", out_word, ew);
          check(out_field == ef, "R4/R5/R6/R10 tag", "field", out_field, ef);
          check(sector_end == ee, "R7", "sector_end", sector_end, ee);
        end
      end else if (sector_end) begin
        check(0, "R7", "sector_end without word", 1, 0);
      end
    end
  end

  task automatic run_sector(input bit ef, input bit es, input bit flip_mid,
                            input bit chk_lat);
    int n = sector_len(ef, es);
    logic [DW-1:0] s_lo = '0;
    logic [DW-1:0] s_hi = '0;
    @(negedge clk);
    flag_en = ef;
    sub_en  = es;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] d = DW'($urandom);
      logic [1:0] t = tag_of(i, ef, es);
      if (t == 2'd3) begin
        if (i == n - 2) s_lo = d; else s_hi = d;
      end
      q_word.push_back(d);
      q_fld.push_back(t);
      q_end.push_back(i == n - 1);
      @(negedge clk);
      word_in = d;
      req_tgl = ~req_tgl;
      if (chk_lat && i == 0) begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R3", "valid early", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R3", "valid at 4th edge", out_valid, 1);
        repeat (1 + $urandom % 4) @(negedge clk);
      end else begin
        repeat (3 + $urandom % 6) @(negedge clk);
      end
      if (i == 1 && flip_mid) begin
        flag_en = ~ef;   // R9: must not alter this sector
        sub_en  = ~es;
      end
      if (i == 4) begin
        check(stat_lo == prev_lo, "R8", "stat_lo held", stat_lo, prev_lo);
        check(stat_hi == prev_hi, "R8", "stat_hi held", stat_hi, prev_hi);
      end
    end
    repeat (8) @(negedge clk);
    check(q_word.size() == 0, "R2", "words missing", q_word.size(), 0);
    check(stat_lo == s_lo, "R8", "stat_lo", stat_lo, s_lo);
    check(stat_hi == s_hi, "R8", "stat_hi", stat_hi, s_hi);
    prev_lo = s_lo;
    prev_hi = s_hi;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd784));
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    check(sector_end == 1'b0, "R1", "end in reset", sector_end, 0);
    check(stat_lo == '0, "R1", "stat_lo in reset", stat_lo, 0);
    check(stat_hi == '0, "R1", "stat_hi in reset", stat_hi, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);

    run_sector(0, 0, 0, 1);
    run_sector(1, 0, 0, 0);   // R5
    run_sector(0, 1, 0, 1);   // R6
    run_sector(1, 1, 0, 0);
    run_sector(1, 0, 1, 0);   // R9
    run_sector(0, 1, 1, 0);   // R9
    for (int k = 0; k < 6; k++) begin
      run_sector(bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule